// File: doc/BRIEF.md
# Transmit Byte Queue with Oldest-Drop Overwrite

This block is the transmit-side byte queue of a 16550-style serial port. It sits between the host's writes to the transmit holding register and the transmit shift register. Host writes are appended to a 16-entry ring. The shift register pulls bytes from it with a single-cycle load request, and it reports the end of each character with a shift-done pulse. The block maintains two status flags: holding-empty, meaning nothing is queued, and transmitter-empty, meaning nothing is queued and nothing is shifting. It also raises the holding-register-empty interrupt request. When the queue is already full, a new write evicts the oldest queued byte rather than being refused.

The register decoder in front of the block turns a write to the FIFO control register into a one-cycle strobe. It passes two decoded bits with that strobe: the FIFO-enable bit (bit 0 of the control value) and the transmit-flush bit (bit 2). With FIFO mode off, the same ring behaves as a single holding register with a capacity of one.

A four-state machine tracks the queue and the shifter together:

- ST_EMPTY: nothing is queued and the shifter is idle. Holding-empty is 1 and transmitter-empty is 1.
- ST_HELD: bytes are queued and the shifter is idle.
- ST_SHIFT: nothing is queued and the shifter is busy. Holding-empty is 1 and transmitter-empty is 0.
- ST_SHIFT_HELD: bytes are queued and the shifter is busy.

The transitions are:

- write: any state goes to ST_HELD or ST_SHIFT_HELD.
- load: ST_HELD or ST_SHIFT_HELD goes to ST_SHIFT_HELD, or to ST_SHIFT when the last byte leaves.
- done: ST_SHIFT goes to ST_EMPTY, and ST_SHIFT_HELD goes to ST_HELD.
- flush: the queued part becomes empty, so ST_HELD goes to ST_EMPTY and ST_SHIFT_HELD goes to ST_SHIFT.

Top module: `uart_txq`

## Requirements
- R1: In FIFO mode the queue retains up to 16 bytes and hands them out oldest first. The occupancy never exceeds 16.
- R2: A host write to a full queue, with no load in the same cycle, discards the oldest byte and appends the new one. The queue still holds 16 bytes afterwards.
- R3: A host write and a granted load in the same cycle on a full queue give the oldest byte to the load and append the new byte. The occupancy stays at 16.
- R4: One cycle after any accepted host write, holding-empty, transmitter-empty and the interrupt request all read 0.
- R5: A load request while bytes are queued pulses `ld_gnt` in the same cycle, with the oldest byte on `ld_data`. A load request on an empty queue gives no grant. A load that takes the last byte sets holding-empty on the next cycle.
- R6: A control strobe with the flush bit set empties the queue. A strobe that changes the FIFO-enable bit empties it as well. A host write or load request in the same cycle as an emptying strobe is discarded.
- R7: With FIFO mode off, the capacity is one byte. A second write replaces the held byte, and a load is granted only while a byte is held.
- R8: A shift-done pulse that leaves the queue empty, with no load in that cycle, sets transmitter-empty on the next cycle. If `thre_ien` is 1 in that cycle, the interrupt request is also raised. If `thre_ien` is 0 in that cycle, no interrupt becomes pending.
- R9: After reset the queue is empty and FIFO mode is off. Holding-empty and transmitter-empty read 1, and the interrupt request reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe for the transmit holding register |
| host_wdata | input | 8 | Byte being written |
| fcr_wr | input | 1 | FIFO control register write strobe |
| fcr_fifo_en | input | 1 | Decoded enable bit (control bit 0) |
| fcr_tx_flush | input | 1 | Decoded transmit flush bit (control bit 2) |
| thre_ien | input | 1 | Holding-register-empty interrupt enable |
| ld_req | input | 1 | Single-cycle load request from the shift register |
| shift_done | input | 1 | Pulse when the shift register finishes a character |
| ld_gnt | output | 1 | Load granted this cycle |
| ld_data | output | 8 | Byte handed to the shift register |
| thr_empty | output | 1 | Holding-empty status |
| tx_empty | output | 1 | Transmitter-empty status |
| thre_irq | output | 1 | Holding-register-empty interrupt request |

## Verification
The hardest case to reach is a full queue receiving a host write and a load request in the same cycle. To get there, the stimulus first fills the ring with exactly 16 known bytes, then raises both strobes in one cycle. It then drains the ring and compares every byte against an arithmetic sequence, so that both the served byte and the preserved order are checked. A sweep over fill levels from 0 to 20 covers the eviction boundary on both sides of 16.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY      = 2'd0,
        ST_HELD       = 2'd1,
        ST_SHIFT      = 2'd2,
        ST_SHIFT_HELD = 2'd3
    } txq_state_e;
endpackage

// File: rtl/txq_ring.sv
module txq_ring #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + PW'(1);
            if (pop)  rptr <= rptr + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign dout = mem[rptr];

    // R1: storage never asked to grow past its depth
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !clr) |-> pop);
    a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import uart_txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_acc,
    input  logic ld_gnt,
    input  logic shift_done,
    input  logic q_more,
    input  logic thre_ien,
    output logic thr_empty,
    output logic tx_empty,
    output logic thre_irq
);
    txq_state_e state_q, state_d;
    logic       busy, busy_d;
    logic       pend_q, pend_d;

    always_comb begin
        busy   = (state_q == ST_SHIFT) || (state_q == ST_SHIFT_HELD);
        busy_d = ld_gnt || (busy && !shift_done);
        unique case ({busy_d, q_more})
            2'b00:   state_d = ST_EMPTY;
            2'b01:   state_d = ST_HELD;
            2'b10:   state_d = ST_SHIFT;
            default: state_d = ST_SHIFT_HELD;
        endcase
        pend_d = pend_q;
        if (wr_acc) begin
            pend_d = 1'b0;
        end else if (shift_done && busy && state_d == ST_EMPTY && thre_ien) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:      begin thr_empty = 1'b1; tx_empty = 1'b1; end
            ST_SHIFT:      begin thr_empty = 1'b1; tx_empty = 1'b0; end
            ST_HELD:       begin thr_empty = 1'b0; tx_empty = 1'b0; end
            default:       begin thr_empty = 1'b0; tx_empty = 1'b0; end
        endcase
        thre_irq = pend_q;
    end

    // R4: an accepted write clears both flags and the request
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> (!thr_empty && !tx_empty && !thre_irq));
    // R8: an interrupt only stands while the transmitter is empty
    a_r8_irq_needs_temt: assert property (@(posedge clk) disable iff (!rst_n)
        thre_irq |-> tx_empty);
    // R8: a disabled source never becomes pending on its own
    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!thre_irq && !thre_ien) |=> !thre_irq);
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          fcr_wr,
    input  logic          fcr_fifo_en,
    input  logic          fcr_tx_flush,
    input  logic          thre_ien,
    input  logic          ld_req,
    input  logic          shift_done,
    output logic          ld_gnt,
    output logic [DW-1:0] ld_data,
    output logic          thr_empty,
    output logic          tx_empty,
    output logic          thre_irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic          fifo_en;
    logic          clr, wr_acc, q_full, pop, q_more;
    logic [CW-1:0] cap, count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fifo_en <= 1'b0;
        else if (fcr_wr) fifo_en <= fcr_fifo_en;
    end

    always_comb begin
        cap    = fifo_en ? CW'(DEPTH) : CW'(1);
        clr    = fcr_wr && (fcr_tx_flush || (fcr_fifo_en != fifo_en));
        wr_acc = host_wr && !clr;
        q_full = count >= cap;
        ld_gnt = ld_req && (count != '0) && !clr;
        pop    = ld_gnt || (wr_acc && q_full);
        q_more = !clr && (wr_acc || (count > CW'(pop)));
    end

    txq_ring #(.DEPTH(DEPTH), .DW(DW)) i_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (wr_acc),
        .pop   (pop),
        .din   (host_wdata),
        .dout  (ld_data),
        .count (count)
    );

    txq_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_acc     (wr_acc),
        .ld_gnt     (ld_gnt),
        .shift_done (shift_done),
        .q_more     (q_more),
        .thre_ien   (thre_ien),
        .thr_empty  (thr_empty),
        .tx_empty   (tx_empty),
        .thre_irq   (thre_irq)
    );

    // R2/R3: a write into a full queue keeps it full
    a_r2_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && wr_acc) |=> (count == $past(cap)));
    // R5: taking the last byte with no write leaves holding-empty set
    a_r5_last_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_gnt && count == CW'(1) && !wr_acc) |=> thr_empty);
    // R6: a flush leaves nothing queued
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && thr_empty));
    // R7: single-register mode never holds more than one byte
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (count <= CW'(1)));
endmodule

// File: tb/test_uart_txq.sv
module test_uart_txq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       fcr_wr = 1'b0;
    logic       fcr_fifo_en = 1'b0;
    logic       fcr_tx_flush = 1'b0;
    logic       thre_ien = 1'b0;
    logic       ld_req = 1'b0;
    logic       shift_done = 1'b0;
    logic       ld_gnt;
    logic [7:0] ld_data;
    logic       thr_empty, tx_empty, thre_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_txq i_uart_txq (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .fcr_wr(fcr_wr), .fcr_fifo_en(fcr_fifo_en), .fcr_tx_flush(fcr_tx_flush),
        .thre_ien(thre_ien), .ld_req(ld_req), .shift_done(shift_done),
        .ld_gnt(ld_gnt), .ld_data(ld_data), .thr_empty(thr_empty),
        .tx_empty(tx_empty), .thre_irq(thre_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        step();
        host_wr = 1'b0;
    endtask

    task automatic fcr(input logic en, input logic fl);
        fcr_wr = 1'b1; fcr_fifo_en = en; fcr_tx_flush = fl;
        step();
        fcr_wr = 1'b0; fcr_tx_flush = 1'b0;
    endtask

    task automatic load_expect(input string req, input logic g, input logic [7:0] b);
        ld_req = 1'b1;
        #1;
        check(req, ld_gnt, g);
        if (g) check(req, ld_data, b);
        step();
        ld_req = 1'b0;
    endtask

    task automatic pulse_done();
        shift_done = 1'b1;
        step();
        shift_done = 1'b0;
    endtask

    function automatic logic [7:0] val(input int n, input int i);
        return 8'((n * 37 + i * 11 + 1) & 8'hFF);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R9: reset state
        check("R9 thr_empty", thr_empty, 1);
        check("R9 tx_empty", tx_empty, 1);
        check("R9 irq", thre_irq, 0);
        load_expect("R9 empty no grant", 1'b0, 8'h00);

        // R7: single-register mode (FIFO off after reset)
        wr(8'h11);
        check("R7 thr_empty after write", thr_empty, 0);
        wr(8'h22);
        load_expect("R7 latest byte", 1'b1, 8'h22);
        load_expect("R7 nothing more", 1'b0, 8'h00);
        check("R7 thr_empty after load", thr_empty, 1);
        pulse_done();

        // enable FIFO mode
        fcr(1'b1, 1'b0);

        // R1/R2: sweep fill levels 0..20, drain and compare
        for (int n = 0; n <= 20; n++) begin
            fcr(1'b1, 1'b1);
            for (int i = 0; i < n; i++) wr(val(n, i));
            check("R1 thr_empty after fill", thr_empty, (n == 0) ? 1 : 0);
            for (int i = (n > 16 ? n - 16 : 0); i < n; i++)
                load_expect((n > 16) ? "R2 evict order" : "R1 order", 1'b1, val(n, i));
            load_expect("R1 drained", 1'b0, 8'h00);
            check("R5 thr_empty after last load", thr_empty, 1);
            if (n > 0) check("R5 tx_empty while shifting", tx_empty, 0);
            pulse_done();
        end

        // R3: full queue, write and load in the same cycle
        fcr(1'b1, 1'b1);
        for (int k = 0; k < 16; k++) wr(8'(8'h40 + k));
        host_wr = 1'b1; host_wdata = 8'hAA; ld_req = 1'b1;
        #1;
        check("R3 grant", ld_gnt, 1);
        check("R3 oldest served", ld_data, 8'h40);
        step();
        host_wr = 1'b0; ld_req = 1'b0;
        for (int k = 1; k < 16; k++) load_expect("R3 order", 1'b1, 8'(8'h40 + k));
        load_expect("R3 new byte last", 1'b1, 8'hAA);
        load_expect("R3 count was 16", 1'b0, 8'h00);

        // R8: shift done with queue empty, interrupt enabled
        thre_ien = 1'b1;
        pulse_done();
        check("R8 tx_empty", tx_empty, 1);
        check("R8 irq raised", thre_irq, 1);
        // R4: write clears flags and request
        wr(8'h5A);
        check("R4 thr_empty", thr_empty, 0);
        check("R4 tx_empty", tx_empty, 0);
        check("R4 irq", thre_irq, 0);
        load_expect("R5 grant", 1'b1, 8'h5A);
        // R8: interrupt disabled at done time
        thre_ien = 1'b0;
        pulse_done();
        check("R8 tx_empty masked", tx_empty, 1);
        check("R8 no pending", thre_irq, 0);
        thre_ien = 1'b1;
        step();
        check("R8 stays clear", thre_irq, 0);

        // R6: flush with simultaneous write discards the write
        for (int k = 0; k < 5; k++) wr(8'(k));
        fcr_wr = 1'b1; fcr_fifo_en = 1'b1; fcr_tx_flush = 1'b1;
        host_wr = 1'b1; host_wdata = 8'hEE;
        step();
        fcr_wr = 1'b0; fcr_tx_flush = 1'b0; host_wr = 1'b0;
        check("R6 thr_empty", thr_empty, 1);
        load_expect("R6 nothing queued", 1'b0, 8'h00);
        // R6: toggling enable empties the queue
        wr(8'h77);
        fcr(1'b0, 1'b0);
        check("R6 enable change empties", thr_empty, 1);
        load_expect("R6 no grant after toggle", 1'b0, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule